// File: doc/BRIEF.md
# Byte-Wide Indirect Register Port

This block lets a host that moves one byte per access reach a bank of 32-bit registers. The host uses two windows. A write to the index window chooses the target register. Four data-window offsets then carry that register's value, one byte per access, most significant byte first. Writes are gathered byte by byte in a staging register, and the whole word reaches the register bank in one strobe. Reads capture the whole word when the first byte is fetched, so the four bytes always belong to the same value.

Index 0 is a read-only identification word that the block itself holds. Indexes 1 to NUM_REGS-1 are handed to downstream logic through a plain read/write strobe interface. Every other index is unimplemented.

Host requests use a valid/ready handshake. A request moves when `host_valid` and `host_ready` are both high on a clock edge. A read response is presented on `rsp_valid`/`rsp_data` from the next cycle. It stays there, unchanged, until `rsp_ready` is high on an edge. While a response waits, `host_ready` is low and no new request is accepted.

Top module: `regwin_port`

## Requirements
- R1: An accepted write to the index window (`host_win`=0) loads the index register. All later data-window accesses target that register, and the offset bits are ignored for index writes.
- R2: Data-window offset 0 carries bits 31:24, offset 1 bits 23:16, offset 2 bits 15:8 and offset 3 bits 7:0.
- R3: Data-window writes at offsets 0, 1 and 2 only fill the staging register. The target register is written, with one `reg_wr_en` pulse in the cycle the offset-3 write is accepted, only when offsets 0, 1, 2 and 3 arrive in that order.
- R4: A data-window write at an offset other than the next expected one breaks the sequence. An out-of-order offset 0 starts a new sequence. Any other out-of-order offset is dropped and the sequence expects offset 0 again. A write to the index window also restarts the sequence. A broken sequence produces no register write.
- R5: A data-window read at offset 0 captures the full selected word into a holding latch and returns its top byte. Reads at offsets 1 to 3 return bytes of that latch, even if the register changes in between. `reg_rd_en` pulses only in the cycle an offset-0 read is accepted.
- R6: Index 0 reads as the identification word: implementation code in bits 31:24, version code in bits 23:16, port count in bits 3:0, and all other bits zero. Writes to index 0 change nothing.
- R7: The index keeps its value until the next index-window write, so repeated word accesses need no new index write.
- R8: An index at or above NUM_REGS reads as zero. Writes to such an index produce no `reg_wr_en`.
- R9: An accepted read returns its response with `rsp_valid` high on the following cycle. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold, `host_ready` is low and requests are not taken.
- R10: An index-window read returns the current index.
- R11: After reset the index is 0, `rsp_valid` and `reg_wr_en` are low and `host_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Block can accept a request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_win | input | 1 | 0 = index window, 1 = data window |
| host_off | input | 2 | Data byte offset |
| host_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 8 | Read response byte |
| reg_wr_en | output | 1 | Register write strobe |
| reg_rd_en | output | 1 | Register read strobe |
| reg_addr | output | IDX_W | Selected register index |
| reg_wdata | output | 32 | Word being written |
| reg_rdata | input | 32 | Word read from the selected register |

## Verification
The bench builds the block with IDX_W=8 and NUM_REGS=8. This leaves indexes 8 to 255 unimplemented, so random indexes land in both the implemented and the unimplemented range. The identification code values are the defaults, which are non-zero in every field, so a misplaced field shows up in the byte reads. The bench acts as the downstream register bank, so it can change a register between the byte reads of one word and so exercise read coherence.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  typedef enum logic {WIN_INDEX = 1'b0, WIN_DATA = 1'b1} win_e;

  localparam int BYTES_PER_WORD = 4;
  localparam int WORD_W = 8 * BYTES_PER_WORD;

  // Byte of a word for a given offset, offset 0 being the most significant.
  function automatic logic [7:0] word_byte(input logic [WORD_W-1:0] w, input logic [1:0] off);
    return w[(BYTES_PER_WORD-1-int'(off))*8 +: 8];
  endfunction
endpackage

// File: rtl/regwin_wrstage.sv
module regwin_wrstage
  import regwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic              restart,
  input  logic [1:0]        off,
  input  logic [7:0]        wbyte,
  output logic              commit,
  output logic [WORD_W-1:0] word
);
  localparam int STAGE_W = WORD_W - 8;

  logic [1:0]         expect_q;
  logic [STAGE_W-1:0] stage_q;
  logic               in_order;

  assign in_order = (off == expect_q);
  assign commit   = wr_fire && in_order && (off == 2'd3);
  assign word     = {stage_q, wbyte};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      expect_q <= '0;
      stage_q  <= '0;
    end else if (restart) begin
      expect_q <= '0;
    end else if (wr_fire) begin
      if (in_order && off == 2'd3) begin
        expect_q <= '0;
      end else if (in_order || off == 2'd0) begin
        stage_q[(2-int'(off))*8 +: 8] <= wbyte;
        expect_q <= off + 2'd1;
      end else begin
        expect_q <= '0;
      end
    end
  end
endmodule

// File: rtl/regwin_rdcap.sv
module regwin_rdcap
  import regwin_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic              win,
  input  logic [1:0]        off,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] src_word,
  input  logic              rsp_ready,
  output logic              cap_en,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data
);
  logic [WORD_W-1:0] hold_q;
  logic [7:0]        next_byte;

  assign cap_en = rd_fire && (win == WIN_DATA) && (off == 2'd0);

  always_comb begin
    if (win == WIN_INDEX) begin
      next_byte = 8'(idx);
    end else if (off == 2'd0) begin
      next_byte = word_byte(src_word, 2'd0);
    end else begin
      next_byte = word_byte(hold_q, off);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (cap_en) hold_q <= src_word;
      if (rd_fire) begin
        rsp_valid <= 1'b1;
        rsp_data  <= next_byte;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/regwin_port.sv
module regwin_port
  import regwin_pkg::*;
#(
  parameter int          IDX_W     = 8,
  parameter int          NUM_REGS  = 8,
  parameter logic [7:0]  IMPL_CODE = 8'h5A,
  parameter logic [7:0]  VER_CODE  = 8'h03,
  parameter logic [3:0]  PORT_CNT  = 4'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_write,
  input  logic              host_win,
  input  logic [1:0]        host_off,
  input  logic [7:0]        host_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_data,
  output logic              reg_wr_en,
  output logic              reg_rd_en,
  output logic [IDX_W-1:0]  reg_addr,
  output logic [WORD_W-1:0] reg_wdata,
  input  logic [WORD_W-1:0] reg_rdata
);
  localparam logic [IDX_W:0]    NUM_L   = (IDX_W+1)'(NUM_REGS);
  localparam logic [IDX_W-1:0]  ID_IDX  = '0;
  localparam logic [WORD_W-1:0] ID_WORD = {IMPL_CODE, VER_CODE, 12'h000, PORT_CNT};

  logic [IDX_W-1:0]  idx_q;
  logic              fire, wr_fire, rd_fire, idx_wr;
  logic              is_id, is_ext;
  logic              commit, cap_en;
  logic [WORD_W-1:0] src_word, stage_word;

  assign host_ready = !rsp_valid;
  assign fire       = host_valid && host_ready;
  assign idx_wr     = fire && host_write && (host_win == WIN_INDEX);
  assign wr_fire    = fire && host_write && (host_win == WIN_DATA);
  assign rd_fire    = fire && !host_write;

  always_ff @(posedge clk) begin
    if (!rst_n) idx_q <= '0;
    else if (idx_wr) idx_q <= host_wdata[IDX_W-1:0];
  end

  assign is_id  = (idx_q == ID_IDX);
  assign is_ext = !is_id && ({1'b0, idx_q} < NUM_L);

  always_comb begin
    if (is_id)       src_word = ID_WORD;
    else if (is_ext) src_word = reg_rdata;
    else             src_word = '0;
  end

  regwin_wrstage u_wrstage (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (wr_fire),
    .restart (idx_wr),
    .off     (host_off),
    .wbyte   (host_wdata),
    .commit  (commit),
    .word    (stage_word)
  );

  regwin_rdcap #(.IDX_W(IDX_W)) u_rdcap (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_fire   (rd_fire),
    .win       (host_win),
    .off       (host_off),
    .idx       (idx_q),
    .src_word  (src_word),
    .rsp_ready (rsp_ready),
    .cap_en    (cap_en),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  assign reg_addr  = idx_q;
  assign reg_wdata = stage_word;
  assign reg_wr_en = commit && is_ext;
  assign reg_rd_en = cap_en && is_ext;
endmodule

// File: rtl/regwin_port_chk.sv
module regwin_port_chk #(
  parameter int IDX_W    = 8,
  parameter int NUM_REGS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_valid,
  input logic              host_ready,
  input logic              host_write,
  input logic              host_win,
  input logic [1:0]        host_off,
  input logic [7:0]        host_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [7:0]        rsp_data,
  input logic              reg_wr_en,
  input logic              reg_rd_en,
  input logic [IDX_W-1:0]  reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata
);
  localparam logic [IDX_W:0] NUM_L = (IDX_W+1)'(NUM_REGS);

  // R9: a stalled response holds
  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R9: every accepted read answers next cycle
  a_r9_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ready && !host_write) |=> rsp_valid);

  // R3: commit only with an accepted offset-3 data write
  a_r3_commit_last: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> (host_valid && host_ready && host_write && host_win && host_off == 2'd3));

  // R8 / R6: strobes only for downstream indexes
  a_r8_no_strobe_unimpl: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en || reg_rd_en) |-> (({1'b0, reg_addr} < NUM_L) && reg_addr != '0));

  // R5: register read only at an accepted offset-0 data read
  a_r5_read_at_first: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |-> (host_valid && host_ready && !host_write && host_win && host_off == 2'd0));

  // R7: index changes only through an index-window write
  a_r7_index_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_valid && host_ready && host_write && !host_win) |=> $stable(reg_addr));
endmodule

bind regwin_port regwin_port_chk #(.IDX_W(IDX_W), .NUM_REGS(NUM_REGS)) i_chk (.*);

// File: tb/test_regwin_port.sv
module test_regwin_port;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 8;
  localparam int NREG = 8;
  localparam logic [31:0] ID_EXP = 32'h5A03_0002;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_valid = 1'b0, host_write = 1'b0, host_win = 1'b0;
  logic [1:0] host_off = '0;
  logic [7:0] host_wdata = '0;
  logic rsp_ready = 1'b0;
  logic host_ready, rsp_valid, reg_wr_en, reg_rd_en;
  logic [7:0] rsp_data;
  logic [IDX_W-1:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  logic [31:0] mem [NREG];
  logic [31:0] expv [NREG];
  int wr_cnt = 0;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regwin_port #(.IDX_W(IDX_W), .NUM_REGS(NREG)) i_regwin_port (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
    .host_write(host_write), .host_win(host_win), .host_off(host_off),
    .host_wdata(host_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // Downstream register bank played by the bench
  assign reg_rdata = (int'(reg_addr) < NREG) ? mem[int'(reg_addr)] : 32'h0;
  always @(posedge clk) begin
    if (reg_wr_en) begin
      wr_cnt <= wr_cnt + 1;
      if (int'(reg_addr) < NREG) mem[int'(reg_addr)] <= reg_wdata;
    end
  end

  function automatic logic [7:0] exp_byte(logic [31:0] w, int off);
    return w[(3-off)*8 +: 8];
  endfunction

  function automatic logic [31:0] exp_word(int idx);
    if (idx == 0) return ID_EXP;
    if (idx < NREG) return expv[idx];
    return 32'h0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hput(logic win, logic [1:0] off, logic [7:0] d);
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b1; host_win = win; host_off = off; host_wdata = d;
    @(posedge clk);
    @(negedge clk);
    host_valid = 1'b0;
  endtask

  task automatic hget(logic win, logic [1:0] off, output logic [7:0] d);
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b0; host_win = win; host_off = off;
    @(posedge clk);
    @(negedge clk);
    host_valid = 1'b0;
    d = rsp_valid ? rsp_data : 8'hxx;
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic put_word(int idx, logic [31:0] v);
    hput(1'b0, 2'd0, 8'(idx));
    for (int k = 0; k < 4; k++) hput(1'b1, 2'(k), exp_byte(v, k));
  endtask

  task automatic get_word(output logic [31:0] v);
    logic [7:0] b;
    for (int k = 0; k < 4; k++) begin
      hget(1'b1, 2'(k), b);
      v[(3-k)*8 +: 8] = b;
    end
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] w;
    logic [7:0] b;
    int cnt0;
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < NREG; i++) begin mem[i] = 32'h0; expv[i] = 32'h0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk("R11 host_ready", 32'(host_ready), 32'h1);
    chk("R11 rsp_valid", 32'(rsp_valid), 32'h0);
    chk("R11 reg_wr_en", 32'(reg_wr_en), 32'h0);
    chk("R11 index", 32'(reg_addr), 32'h0);
    rst_n = 1'b1;

    // R6 identification word, and writes to it ignored
    hget(1'b0, 2'd0, b); chk("R10 index read after reset", 32'(b), 32'h0);
    get_word(w); chk("R6 id word", w, ID_EXP);
    cnt0 = wr_cnt;
    put_word(0, 32'hFFFF_FFFF);
    get_word(w); chk("R6 id after write", w, ID_EXP);
    chk("R6 no strobe", 32'(wr_cnt - cnt0), 32'h0);

    // R1 R2 byte order
    put_word(2, 32'hA1B2_C3D4); expv[2] = 32'hA1B2_C3D4;
    chk("R1 bank value", mem[2], 32'hA1B2_C3D4);
    for (int k = 0; k < 4; k++) begin
      hget(1'b1, 2'(k), b);
      chk("R2 byte order", 32'(b), 32'(exp_byte(32'hA1B2_C3D4, k)));
    end
    hget(1'b0, 2'd3, b); chk("R10 index read", 32'(b), 32'h2);

    // R3 no commit before offset 3
    cnt0 = wr_cnt;
    hput(1'b0, 2'd0, 8'd3);
    hput(1'b1, 2'd0, 8'h11); hput(1'b1, 2'd1, 8'h22); hput(1'b1, 2'd2, 8'h33);
    chk("R3 no early commit", mem[3], 32'h0);
    chk("R3 no early strobe", 32'(wr_cnt - cnt0), 32'h0);
    hput(1'b1, 2'd3, 8'h44); expv[3] = 32'h1122_3344;
    chk("R3 commit", mem[3], 32'h1122_3344);
    chk("R3 one strobe", 32'(wr_cnt - cnt0), 32'h1);

    // R4 out-of-order dropped; offset 0 restarts
    cnt0 = wr_cnt;
    hput(1'b1, 2'd0, 8'hAA); hput(1'b1, 2'd2, 8'hBB); hput(1'b1, 2'd3, 8'hCC);
    chk("R4 skipped offset no commit", 32'(wr_cnt - cnt0), 32'h0);
    hput(1'b1, 2'd0, 8'h55); hput(1'b1, 2'd1, 8'h66); hput(1'b1, 2'd0, 8'h77);
    hput(1'b1, 2'd1, 8'h88); hput(1'b1, 2'd2, 8'h99); hput(1'b1, 2'd3, 8'h10);
    expv[3] = 32'h7788_9910;
    chk("R4 restart commit", mem[3], 32'h7788_9910);
    cnt0 = wr_cnt;
    hput(1'b1, 2'd0, 8'h01); hput(1'b1, 2'd1, 8'h02); hput(1'b0, 2'd0, 8'd3);
    hput(1'b1, 2'd2, 8'h03); hput(1'b1, 2'd3, 8'h04);
    chk("R4 index write restarts", 32'(wr_cnt - cnt0), 32'h0);

    // R7 index persists; R5 coherent capture
    hget(1'b1, 2'd0, b); chk("R5 first byte", 32'(b), 32'h77);
    mem[3] = 32'hDEAD_BEEF;
    hget(1'b1, 2'd1, b); chk("R5 latched byte1", 32'(b), 32'h88);
    hget(1'b1, 2'd2, b); chk("R5 latched byte2", 32'(b), 32'h99);
    hget(1'b1, 2'd3, b); chk("R5 latched byte3", 32'(b), 32'h10);
    get_word(w); chk("R7 reread without index write", w, 32'hDEAD_BEEF);
    mem[3] = 32'h7788_9910;

    // R8 unimplemented index
    cnt0 = wr_cnt;
    put_word(200, 32'h1234_5678);
    get_word(w); chk("R8 reads zero", w, 32'h0);
    chk("R8 no strobe", 32'(wr_cnt - cnt0), 32'h0);
    put_word(NREG, 32'h1234_5678);
    get_word(w); chk("R8 first unimplemented", w, 32'h0);

    // R9 back-pressure
    hput(1'b0, 2'd0, 8'd2);
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b0; host_win = 1'b1; host_off = 2'd0;
    @(posedge clk);
    @(negedge clk);
    host_write = 1'b1; host_win = 1'b0; host_wdata = 8'd5;
    for (int k = 0; k < 3; k++) begin
      chk("R9 response held", 32'({rsp_valid, rsp_data}), 32'h1A1);
      chk("R9 not ready", 32'(host_ready), 32'h0);
      @(negedge clk);
    end
    host_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    hget(1'b0, 2'd0, b); chk("R9 stalled request not taken", 32'(b), 32'h2);

    // Random word traffic
    for (int it = 0; it < 60; it++) begin
      int idx;
      logic [31:0] v;
      idx = int'($urandom_range(0, 15));
      v = $urandom;
      put_word(idx, v);
      if (idx != 0 && idx < NREG) expv[idx] = v;
      idx = int'($urandom_range(0, 15));
      hput(1'b0, 2'd0, 8'(idx));
      get_word(w);
      chk("R1 random word", w, exp_word(idx));
    end

    finish_run();
  end
endmodule